// File: doc/BRIEF.md
# Bit-Packed Stream Unpacker

This block turns a byte stream of densely packed unsigned integers back into one value per output word. The packed field width is chosen per run, from 1 to 16 bits. Every decoded value is zero-extended to a 16-bit word. Values travel in groups of eight. A full group fills exactly as many bytes as the field width, so every group ends on a byte boundary.

A run begins with a one-cycle `start` pulse, which latches the field width and the total number of values. The block then takes the bytes of one group into a small buffer. It emits that group's values one per cycle under a valid/ready handshake, then goes on to fetch the next group. If the value count is not a multiple of eight, the last group takes only the bytes its remaining values need. The missing upper bits of that group are read as zero, so the producer never has to pad the stream. The extraction step is the same shift-then-mask operation for every width. Only the group byte count, the per-value bit offset and the mask depend on the configured width.

Top module: `bitunpack16`

## Requirements
- R1: A `start` pulse while idle with a width of 1 to 16 latches width and count, clears `cfg_err`, and raises `in_ready` in the next cycle when the count is non-zero.
- R2: Packing is least-significant-bit first. Value k of a group begins at bit k×width of that group's bytes (bit 0 is bit 0 of the group's first byte). Each value appears on `out_data` with every bit at or above the width cleared.
- R3: A full group of eight values takes exactly width bytes. `in_ready` and `out_valid` are never high together, so input waits while a buffered group is still being emitted.
- R4: When r < 8 values remain, the last group takes ceil(r×width/8) bytes and emits only r values. Its absent upper bits decode as zero.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.
- R6: Exactly count values are emitted, in index order. `done` is high for exactly one cycle, the cycle after the last value is accepted.
- R7: A `start` with width 0 or above 16 raises `cfg_err` in the next cycle. `cfg_err` stays high until the next `start`, and meanwhile `in_ready` and `out_valid` stay low.
- R8: Outside a run `in_ready` is low, so offered bytes are not taken. A `start` pulse during a run has no effect on that run.
- R9: A valid `start` with a count of zero produces `done` in the next cycle and no output.
- R10: After reset `in_ready`, `out_valid`, `done` and `cfg_err` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a run |
| cfg_width | input | 5 | Field width in bits, valid 1 to 16 |
| cfg_count | input | CNT_W (16) | Total values in the run |
| cfg_err | output | 1 | Last start carried an illegal width |
| in_valid | input | 1 | Packed byte offered |
| in_data | input | 8 | Packed byte |
| in_ready | output | 1 | Block takes the offered byte |
| out_valid | output | 1 | Decoded value present |
| out_data | output | 16 | Decoded value, zero-extended |
| out_ready | input | 1 | Consumer takes the value |
| done | output | 1 | One-cycle pulse after the last value |

## Verification
`in_ready`, `cfg_err` and the zero-count `done` are due one cycle after the edge that samples `start`. The first value of a group is offered the cycle after its last byte is taken, and `done` follows the cycle after the last output handshake. Every port is driven on the falling edge and read one time unit later, while the registered state is settled and the next rising edge is still ahead. A handshake is counted only when both sides are seen high at that point. The bench logs the cycle index of each handshake, so it can compare the `done` cycle and the byte consumption against the expected values exactly.

// File: rtl/bitunpack_pkg.sv
package bitunpack_pkg;

    // Values per packing group; the framing depends on this being eight.
    localparam int unsigned GROUP_VALS = 8;
    localparam int unsigned VIDX_W     = $clog2(GROUP_VALS);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_EMIT = 2'd2,
        ST_DONE = 2'd3
    } bu_state_e;

endpackage

// File: rtl/bu_group_plan.sv
// Size of the current group: values in it and bytes it occupies.
module bu_group_plan #(
    parameter int unsigned OUT_W  = 16,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned WID_W  = 5,
    parameter int unsigned NEED_W = 5
) (
    input  logic [CNT_W-1:0]  remain,
    input  logic [WID_W-1:0]  width,
    output logic [3:0]        grp_vals,
    output logic [NEED_W-1:0] grp_bytes
);
    import bitunpack_pkg::*;

    localparam int unsigned BITS_W = $clog2(GROUP_VALS * OUT_W + 8) + 1;

    logic [BITS_W-1:0] grp_bits;
    logic [BITS_W-1:0] rounded;

    always_comb begin
        if (remain >= CNT_W'(GROUP_VALS)) begin
            grp_vals = 4'(GROUP_VALS);
        end else begin
            grp_vals = 4'(remain);
        end
        grp_bits  = BITS_W'(grp_vals) * BITS_W'(width);
        rounded   = (grp_bits + BITS_W'(7)) >> 3;
        grp_bytes = NEED_W'(rounded);
    end

endmodule

// File: rtl/bu_gather.sv
// Byte-addressed group buffer; a clear zeroes all bytes so short tails read as zero.
module bu_gather #(
    parameter int unsigned NBYTES = 16,
    parameter int unsigned IDX_W  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [7:0]            wr_byte,
    output logic [NBYTES*8-1:0]   grp_bits
);

    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        logic [7:0] byte_d;
        logic [7:0] byte_q;

        always_comb begin
            byte_d = byte_q;
            if (clr) begin
                byte_d = '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                byte_d = wr_byte;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                byte_q <= '0;
            end else begin
                byte_q <= byte_d;
            end
        end

        assign grp_bits[i*8 +: 8] = byte_q;
    end

endmodule

// File: rtl/bu_extract.sv
// Width-independent field extractor: shift right by offset, keep width low bits.
module bu_extract #(
    parameter int unsigned BUF_W = 128,
    parameter int unsigned OUT_W = 16,
    parameter int unsigned OFF_W = 7,
    parameter int unsigned WID_W = 5
) (
    input  logic [BUF_W-1:0] src,
    input  logic [OFF_W-1:0] offset,
    input  logic [WID_W-1:0] width,
    output logic [OUT_W-1:0] value
);

    logic [BUF_W-1:0] shifted;
    logic [OUT_W:0]   mask_ext;

    always_comb begin
        shifted  = src >> offset;
        mask_ext = ({{OUT_W{1'b0}}, 1'b1} << width) - 1'b1;
        value    = shifted[OUT_W-1:0] & mask_ext[OUT_W-1:0];
    end

endmodule

// File: rtl/bitunpack16.sv
module bitunpack16 #(
    parameter int unsigned OUT_W = 16,
    parameter int unsigned CNT_W = 16,
    localparam int unsigned WID_W = $clog2(OUT_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WID_W-1:0] cfg_width,
    input  logic [CNT_W-1:0] cfg_count,
    output logic             cfg_err,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data,
    input  logic             out_ready,
    output logic             done
);
    import bitunpack_pkg::*;

    localparam int unsigned GRP_BYTES = (GROUP_VALS * OUT_W) / 8;
    localparam int unsigned BUF_W     = GRP_BYTES * 8;
    localparam int unsigned BIDX_W    = $clog2(GRP_BYTES);
    localparam int unsigned NEED_W    = $clog2(GRP_BYTES + 1);
    localparam int unsigned OFF_W     = $clog2(BUF_W);

    typedef struct packed {
        bu_state_e         st;
        logic [WID_W-1:0]  width;
        logic [CNT_W-1:0]  remain;
        logic [BIDX_W-1:0] bidx;
        logic [VIDX_W-1:0] vidx;
        logic              err;
    } ctrl_t;

    ctrl_t r_d;
    ctrl_t r_q;

    logic              buf_clr;
    logic              buf_wr;
    logic [BUF_W-1:0]  grp_bits;
    logic [3:0]        grp_vals;
    logic [NEED_W-1:0] grp_bytes;
    logic [OFF_W-1:0]  bit_off;
    logic [WID_W-1:0]  width_q;

    bu_group_plan #(
        .OUT_W (OUT_W),
        .CNT_W (CNT_W),
        .WID_W (WID_W),
        .NEED_W(NEED_W)
    ) u_plan (
        .remain   (r_q.remain),
        .width    (r_q.width),
        .grp_vals (grp_vals),
        .grp_bytes(grp_bytes)
    );

    bu_gather #(
        .NBYTES(GRP_BYTES),
        .IDX_W (BIDX_W)
    ) u_gather (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (buf_clr),
        .wr_en   (buf_wr),
        .wr_idx  (r_q.bidx),
        .wr_byte (in_data),
        .grp_bits(grp_bits)
    );

    assign bit_off = OFF_W'(r_q.vidx) * OFF_W'(r_q.width);

    bu_extract #(
        .BUF_W(BUF_W),
        .OUT_W(OUT_W),
        .OFF_W(OFF_W),
        .WID_W(WID_W)
    ) u_extract (
        .src   (grp_bits),
        .offset(bit_off),
        .width (r_q.width),
        .value (out_data)
    );

    always_comb begin
        r_d     = r_q;
        buf_clr = 1'b0;
        buf_wr  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.width  = cfg_width;
                    r_d.remain = cfg_count;
                    r_d.bidx   = '0;
                    r_d.vidx   = '0;
                    if ((cfg_width == '0) || (cfg_width > WID_W'(OUT_W))) begin
                        r_d.err = 1'b1;
                    end else begin
                        r_d.err = 1'b0;
                        if (cfg_count == '0) begin
                            r_d.st = ST_DONE;
                        end else begin
                            r_d.st  = ST_FILL;
                            buf_clr = 1'b1;
                        end
                    end
                end
            end
            ST_FILL: begin
                if (in_valid) begin
                    buf_wr = 1'b1;
                    if (NEED_W'(r_q.bidx) == (grp_bytes - 1'b1)) begin
                        r_d.bidx = '0;
                        r_d.st   = ST_EMIT;
                    end else begin
                        r_d.bidx = r_q.bidx + 1'b1;
                    end
                end
            end
            ST_EMIT: begin
                if (out_ready) begin
                    r_d.remain = r_q.remain - 1'b1;
                    if (r_q.remain == CNT_W'(1)) begin
                        r_d.st = ST_DONE;
                    end else if (r_q.vidx == VIDX_W'(GROUP_VALS - 1)) begin
                        r_d.vidx = '0;
                        r_d.st   = ST_FILL;
                        buf_clr  = 1'b1;
                    end else begin
                        r_d.vidx = r_q.vidx + 1'b1;
                    end
                end
            end
            ST_DONE: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, width: '0, remain: '0, bidx: '0, vidx: '0, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign in_ready  = (r_q.st == ST_FILL);
    assign out_valid = (r_q.st == ST_EMIT);
    assign done      = (r_q.st == ST_DONE);
    assign cfg_err   = r_q.err;
    assign width_q   = r_q.width;

    // Group size only matters while filling; keep the count visible to readers.
    logic unused_vals;
    assign unused_vals = ^grp_vals;

endmodule

// File: rtl/bu_checker.sv
module bu_checker #(
    parameter int unsigned OUT_W = 16,
    parameter int unsigned WID_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [OUT_W-1:0] out_data,
    input logic             done,
    input logic             cfg_err,
    input logic [WID_W-1:0] width_q
);

    // R3: input and output phases never overlap
    p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    // R5: a stalled value is held
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R7: an illegal width keeps both handshakes quiet
    p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!in_ready && !out_valid));

    // R6: done lasts one cycle and the block is idle after it
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !in_ready && !out_valid));

    // R2: no bit at or above the configured width is set
    p_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_data >> width_q) == '0));

endmodule

bind bitunpack16 bu_checker #(
    .OUT_W(OUT_W),
    .WID_W(WID_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .done     (done),
    .cfg_err  (cfg_err),
    .width_q  (width_q)
);

// File: tb/bitunpack16_tb.sv
module bitunpack16_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;
    localparam int MAXN       = 128;
    localparam int MAXB       = MAXN * 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  cfg_width = '0;
    logic [15:0] cfg_count = '0;
    logic        cfg_err;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready;
    logic        out_valid;
    logic [15:0] out_data;
    logic        out_ready = 1'b0;
    logic        done;

    int checks = 0;
    int errors = 0;

    logic [15:0] exp_v [MAXN];
    logic [7:0]  pk    [MAXB];
    int          nbytes;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bitunpack16 #(.OUT_W(16), .CNT_W(CNT_W)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cfg_width(cfg_width),
        .cfg_count(cfg_count),
        .cfg_err  (cfg_err),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_ready (in_ready),
        .out_valid(out_valid),
        .out_data (out_data),
        .out_ready(out_ready),
        .done     (done)
    );

    function automatic void chk(input bit ok, input string req, input string what,
                                input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endfunction

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
    end

    // Pack n random w-bit values LSB-first into pk.
    task automatic prepare(input int w, input int n);
        for (int i = 0; i < MAXB; i++) pk[i] = '0;
        for (int i = 0; i < n; i++) begin
            exp_v[i] = 16'($urandom & ((32'd1 << w) - 1));
            for (int b = 0; b < w; b++) begin
                int pos;
                pos = i * w + b;
                pk[pos / 8][pos % 8] = exp_v[i][b];
            end
        end
        nbytes = (n * w + 7) / 8;
    endtask

    task automatic pulse_start(input int w, input int n);
        @(negedge clk);
        start     = 1'b1;
        cfg_width = 5'(w);
        cfg_count = 16'(n);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic idle_probe(input string req);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            in_valid  = 1'b1;
            in_data   = 8'($urandom);
            out_ready = 1'b1;
            #1;
            chk(!in_ready, req, "in_ready while idle", int'(in_ready), 0);
            chk(!out_valid, req, "out_valid while idle", int'(out_valid), 0);
        end
        in_valid  = 1'b0;
        out_ready = 1'b0;
    endtask

    task automatic run(input int w, input int n, input bit inject);
        int ptr, oidx, iter, last_out, done_iter;
        bit held;
        logic [15:0] held_data;
        prepare(w, n);
        pulse_start(w, n);
        #1;
        chk(in_ready && !cfg_err, "R1", "in_ready after start", int'(in_ready), 1);
        ptr = 0; oidx = 0; iter = 0; last_out = -1; done_iter = -1; held = 0;
        held_data = '0;
        forever begin
            in_valid  = (ptr < nbytes) && ($urandom % 4 != 0);
            in_data   = in_valid ? pk[ptr] : 8'($urandom);
            out_ready = ($urandom % 3 != 0);
            start     = inject && (iter == 5);
            if (start) begin
                cfg_width = 5'd7;
                cfg_count = 16'd3;
            end
            #1;
            if (held) begin
                chk(out_valid && out_data == held_data, "R5", "held value",
                    int'(out_data), int'(held_data));
            end
            held = out_valid && !out_ready;
            held_data = out_data;
            if (done) begin
                done_iter = iter;
                break;
            end
            if (in_valid && in_ready) ptr++;
            if (out_valid && out_ready) begin
                if (oidx < n) begin
                    chk(out_data == exp_v[oidx], "R2", $sformatf("w%0d value %0d", w, oidx),
                        int'(out_data), int'(exp_v[oidx]));
                end else begin
                    chk(0, "R6", "extra value", oidx, n);
                end
                oidx++;
                last_out = iter;
            end
            @(negedge clk);
            iter++;
            if (iter > 20000) begin
                chk(0, "R6", "run never finished", iter, 0);
                break;
            end
        end
        start = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
        if (n % 8 != 0) chk(ptr == nbytes, "R4", "bytes taken with tail", ptr, nbytes);
        else            chk(ptr == nbytes, "R3", "bytes taken full groups", ptr, nbytes);
        chk(oidx == n, "R6", "values emitted", oidx, n);
        chk(done_iter == last_out + 1, "R6", "done cycle", done_iter, last_out + 1);
        @(negedge clk); #1;
        chk(!done, "R6", "done width", int'(done), 0);
        idle_probe("R8");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        #1;
        chk(!in_ready && !out_valid && !done && !cfg_err, "R10", "reset outputs",
            int'({in_ready, out_valid, done, cfg_err}), 0);
        rst_n = 1'b1;

        // R7: illegal widths
        pulse_start(0, 10);
        #1;
        chk(cfg_err, "R7", "error on width 0", int'(cfg_err), 1);
        idle_probe("R7");
        pulse_start(17, 10);
        #1;
        chk(cfg_err, "R7", "error on width 17", int'(cfg_err), 1);
        idle_probe("R7");

        // R9: zero count
        pulse_start(5, 0);
        #1;
        chk(done && !out_valid, "R9", "done after zero count", int'(done), 1);
        chk(!cfg_err, "R1", "error cleared", int'(cfg_err), 0);
        @(negedge clk); #1;
        chk(!done && !out_valid, "R9", "single done", int'(done), 0);

        // Directed corners
        run(16, 1, 0);
        run(16, 64, 0);
        run(1, 7, 0);
        run(13, 127, 0);
        run(3, 8, 0);
        run(9, 50, 1);   // R8: start mid-run ignored

        // Every width, tail and full-group counts
        for (int w = 1; w <= 16; w++) begin
            run(w, 1 + int'($urandom % 40), 0);
            run(w, 8 * (1 + int'($urandom % 4)), 0);
            run(w, 8 * int'($urandom % 3) + 1 + int'($urandom % 7), w % 4 == 0);
        end

        summary();
    end

endmodule